// File: doc/BRIEF.md
# Two-Stage I2C Clock Divider

This block turns a fast reference clock into the timing an I2C master needs. Two programmable prescalers run in cascade. The first is a 2-bit stage that divides the reference. The second is a 6-bit stage that advances only when the first stage reaches its terminal count. When both stages reach terminal count on the same cycle, the block emits a one-cycle sample-enable strobe. The master uses this strobe to sample the incoming SCL and SDA lines.

A fixed divide-by-22 stage counts these strobes and produces the outgoing SCL waveform. It holds SCL low for 11 strobes and high for 11 strobes, so the duty cycle is 50%. It also emits a one-cycle marker at the start of each SCL period.

Both divider values come from a 16-bit configuration word that the block reads every cycle. A new divider value is loaded only when the counter it controls reaches terminal count. A counter that is part way through its count is therefore never cut short, and the strobe never glitches.

Top module: `i2c_clkdiv`

## Requirements
- R1: The first divider value (called A below) is taken from `cfg_word[15:14]` and the second (called B) from `cfg_word[13:8]`. Bits 7:0 of `cfg_word` have no effect on any output.
- R2: With the configuration held steady, `smp_en` is high for exactly one reference cycle in every (A+1)*(B+1) cycles. The case A=B=0 gives a strobe on every cycle.
- R3: `scl_level` changes only on a cycle where `smp_en` is high. It stays low for 11 strobes and then high for 11 strobes, so one SCL period is 22*(A+1)*(B+1) reference cycles.
- R4: `scl_tick` is high for one cycle, exactly on the cycle where `scl_level` goes from high to low. That cycle is always a strobe cycle.
- R5: While `rst_n` is low, `scl_level` is 1 and both `smp_en` and `scl_tick` are 0. On the first rising clock edge after reset is released, the block issues a strobe, drives `scl_level` low and pulses `scl_tick`.
- R6: A change to A or B mid-run takes effect at the next strobe. The interval from that strobe to the following one, and every interval after it, equals the new (A+1)*(B+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset. It must be released synchronously to `clk`. |
| cfg_word | input | 16 | Configuration word. The divider values are in bits 15:14 (A) and 13:8 (B). |
| smp_en | output | 1 | One-cycle sample-enable strobe |
| scl_level | output | 1 | Outgoing SCL level; 1 means released (high). |
| scl_tick | output | 1 | One-cycle pulse at the start of each SCL period (the falling edge of SCL) |

## Verification
The bench builds the block with its default parameters: a 16-bit configuration word, a 2-bit and a 6-bit prescaler, and a divide-by-22 SCL stage. Together these put both corner settings within reach. The fastest setting, A=0 and B=0, gives a strobe on every cycle. The slowest, A=3 and B=63, gives a 256-cycle strobe period and a 5632-cycle SCL period.

For each divider pair, the bench compares every output, cycle by cycle, against a model based on the cycle index. Throughout these runs it scrambles the low byte of `cfg_word`. A separate run changes both divider fields mid-run and measures the strobe intervals that follow the change.

// File: rtl/i2c_clkdiv_pkg.sv
package i2c_clkdiv_pkg;
  localparam int unsigned CFG_W    = 16;
  localparam int unsigned A_W      = 2;
  localparam int unsigned A_LSB    = 14;
  localparam int unsigned B_W      = 6;
  localparam int unsigned B_LSB    = 8;
  localparam int unsigned SCL_DIV  = 22;
endpackage

// File: rtl/i2c_clkdiv_stage.sv
// Down-counting prescaler: reloads its limit only at terminal count.
module i2c_clkdiv_stage #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         tc
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tc = en && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (cnt_q == '0) cnt_d = lim;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a stalled stage keeps its count
  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));

  // R6: terminal count loads the limit present at that edge
  assert_reload_at_tc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> (cnt_q == $past(lim)));
endmodule

// File: rtl/i2c_clkdiv_scl.sv
// Counts strobes and toggles SCL every HALF strobes.
module i2c_clkdiv_scl #(
  parameter int unsigned HALF = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic scl_level,
  output logic scl_tick
);
  localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] hcnt_q, hcnt_d;
  logic          lvl_q, lvl_d;
  logic          tick_q, tick_d;

  always_comb begin
    hcnt_d = hcnt_q;
    lvl_d  = lvl_q;
    tick_d = 1'b0;
    if (strobe) begin
      if (hcnt_q == '0) begin
        hcnt_d = HW'(HALF - 1);
        lvl_d  = ~lvl_q;
        tick_d = lvl_q;
      end else begin
        hcnt_d = hcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      lvl_q  <= 1'b1;
      tick_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      lvl_q  <= lvl_d;
      tick_q <= tick_d;
    end
  end

  assign scl_level = lvl_q;
  assign scl_tick  = tick_q;

  assert_half_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt_q <= HW'(HALF - 1));

  assert_tick_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (!lvl_q && $past(lvl_q)));
endmodule

// File: rtl/i2c_clkdiv.sv
module i2c_clkdiv
  import i2c_clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             smp_en,
  output logic             scl_level,
  output logic             scl_tick
);
  localparam int unsigned HALF = SCL_DIV / 2;

  logic [A_W-1:0] div_a;
  logic [B_W-1:0] div_b;
  logic           a_tc, b_tc;
  logic           smp_q;

  assign div_a = cfg_word[A_LSB +: A_W];
  assign div_b = cfg_word[B_LSB +: B_W];

  i2c_clkdiv_stage #(.W(A_W)) u_stage_a (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .lim(div_a), .tc(a_tc)
  );

  i2c_clkdiv_stage #(.W(B_W)) u_stage_b (
    .clk(clk), .rst_n(rst_n), .en(a_tc), .lim(div_b), .tc(b_tc)
  );

  i2c_clkdiv_scl #(.HALF(HALF)) u_scl (
    .clk(clk), .rst_n(rst_n), .strobe(b_tc),
    .scl_level(scl_level), .scl_tick(scl_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= 1'b0;
    else        smp_q <= b_tc;
  end

  assign smp_en = smp_q;

  assert_level_moves_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_level != $past(scl_level)) |-> smp_en);

  assert_tick_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scl_tick |-> smp_en);
endmodule

// File: tb/i2c_clkdiv_tb.sv
module i2c_clkdiv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_word = 16'h0;
  logic        smp_en, scl_level, scl_tick;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_clkdiv u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .smp_en(smp_en), .scl_level(scl_level), .scl_tick(scl_tick)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Cycle-exact run with steady fields and a scrambled low byte (R1, R2, R3, R4, R5)
  task automatic run_cfg(input int a, input int b);
    int p = (a + 1) * (b + 1);
    int ncyc = p * 44 + 20;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_word = {a[1:0], b[5:0], 8'h00};
    @(negedge clk);
    chk("R5", scl_level, 1, "reset scl_level");
    chk("R5", smp_en, 0, "reset smp_en");
    chk("R5", scl_tick, 0, "reset scl_tick");
    rst_n = 1'b1;
    for (int n = 0; n < ncyc; n++) begin
      @(negedge clk);
      begin
        int j = n / p;
        int s = (n % p == 0) ? 1 : 0;
        int lv = (((j / 11) + 1) % 2 == 0) ? 1 : 0;
        int tk = (s == 1 && (j % 22) == 0) ? 1 : 0;
        chk((n == 0) ? "R5" : "R2", smp_en, s, $sformatf("smp_en a=%0d b=%0d n=%0d", a, b, n));
        chk("R3", scl_level, lv, $sformatf("scl_level a=%0d b=%0d n=%0d", a, b, n));
        chk("R4", scl_tick, tk, $sformatf("scl_tick a=%0d b=%0d n=%0d", a, b, n));
      end
      cfg_word[7:0] = 8'($urandom);  // R1: low byte must not matter
    end
  endtask

  // Live field change (R6)
  task automatic run_change();
    int seen = 0;
    int last = -1;
    int idx = 0;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_word = {2'd1, 6'd1, 8'h5a};
    @(negedge clk);
    rst_n = 1'b1;
    repeat (13) @(negedge clk);
    cfg_word = {2'd2, 6'd3, 8'ha5};  // new period 12
    while (seen < 4 && idx < 200) begin
      @(negedge clk);
      idx++;
      if (smp_en) begin
        if (seen >= 1) chk("R6", idx - last, 12, $sformatf("interval after change #%0d", seen));
        last = idx;
        seen++;
      end
    end
    chk("R6", seen, 4, "strobes after change");
  endtask

  initial begin
    fork
      begin
        run_cfg(0, 0);
        run_cfg(1, 2);
        run_cfg(2, 5);
        run_cfg(0, 7);
        run_cfg(3, 63);
        run_change();
        done = 1;
      end
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          n_vec++;
          n_bad++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule